// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is the configuration port of a clock-distribution chip. It has nine 28-bit configuration registers and a non-volatile shadow copy of the first eight. A host reaches it through a four-wire serial port: a serial clock, a data-in line, a data-out line with its own enable, and an active-low latch enable. Every transfer is one fixed 32-bit frame, sent least significant bit first. The low four bits of a frame are a code and the upper 28 bits are a data word. The code selects one of four actions: write a register, request a read-back, copy the registers into the shadow, or copy into the shadow and then lock it for good.

The serial clock, the latch enable and the data-in line each pass through a two-flop synchroniser into the faster system clock, and all edge detection happens there. Reading a register takes two frames. The first frame names the register, and the second frame carries its value out. A copy into the shadow starts a busy interval, counted in system clocks. Any frame that begins during that interval is ignored. A warm reset reloads the working registers from the shadow. A power-on reset first restores the shadow to its default contents and clears the lock. The register contents leave the block as one flat bus that feeds the output-channel logic.

Top module: `cfg_spi_slave`

## Requirements
- R1: A frame is exactly 32 bits, sent least significant bit first. Bits 3:0 are the code and bits 31:4 are the data word. A data bit is taken on each rising edge of the synchronised serial clock while latch enable is low, and the frame is acted on at the rising edge of latch enable.
- R2: While latch enable is high, serial clock edges shift nothing in and change no register.
- R3: Codes 0 to 8 write the data word into the register with that number. Register 8 is a working-only register and is never saved to the shadow. Register i appears on regFlat[28*i+27:28*i].
- R4: Code 0xE with data bits 3:0 equal to t selects register t for read-back. During the next low period of latch enable, miso shifts out the 32-bit word {register t, t} least significant bit first. Bit 0 is present from the start of that period, and the next bit appears after each falling serial clock edge. A target above 8 returns zero in the register field.
- R5: A frame that ends with a bit count other than 32 is discarded and changes nothing.
- R6: Code 0xF with data 0x0000001 copies registers 0 to 7 into the shadow, as long as the shadow is not locked. This copy may be repeated any number of times.
- R7: Code 0xF with data 0x0000A03 copies registers 0 to 7 into the shadow and then locks it. Once locked, the shadow cannot change and a copy command starts no busy interval, while register writes still work.
- R8: An accepted copy raises busy for BUSY_CYCLES system clocks. A frame whose latch-enable fall arrives while busy is high is ignored.
- R9: A warm reset (rstN low) loads registers 0 to 7 from the shadow and clears register 8. A power-on reset (porN low) sets the shadow to its defaults, clears the lock and loads those defaults. The defaults are 0x8140000 for registers 0 to 4, 0x0000096 for register 5, 0x0000000 for register 6 and 0x9400000 for register 7.
- R10: misoEn is high only while the synchronised latch enable is low.
- R11: Codes 9 to 0xD, and code 0xF with any data word other than the two keys, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial port |
| rstN | input | 1 | Synchronous active-low warm reset; reloads the registers from the shadow |
| porN | input | 1 | Synchronous active-low power-on reset; restores the shadow defaults and clears the lock |
| sclk | input | 1 | Serial clock from the host |
| latchN | input | 1 | Active-low latch enable that frames each transfer |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial read-back data |
| misoEn | output | 1 | Drive enable for miso; low means high-impedance |
| busy | output | 1 | High while a shadow write is in progress |
| regFlat | output | 252 | All nine configuration registers, register 0 in the low bits |

## Verification
The hardest state to reach from the ports is the one after the shadow has been locked. A locked shadow looks just like an unlocked one until a later reset brings its contents back. The stimulus therefore locks the shadow, changes the working registers, and issues an unlock copy, which must leave busy low. It then pulses only the warm reset and compares the reloaded registers with the values that were captured at the lock. A frame that starts while busy is high is reached by starting it a few clocks after a copy frame ends.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;

  localparam logic [3:0]  CODE_READ = 4'hE;
  localparam logic [3:0]  CODE_COPY = 4'hF;
  localparam logic [27:0] KEY_COPY  = 28'h0000001;
  localparam logic [27:0] KEY_LOCK  = 28'h0000A03;

  typedef struct packed {
    logic start;
    logic shiftIn;
    logic shiftOut;
    logic commit;
  } ctrlStb_t;

  function automatic logic [27:0] shadowDefault(input int idx);
    if (idx <= 4)      return 28'h8140000;
    else if (idx == 5) return 28'h0000096;
    else if (idx == 7) return 28'h9400000;
    else               return 28'h0000000;
  endfunction

endpackage

// File: rtl/cfgspi_ctrl.sv
module cfgspi_ctrl
  import cfgspi_pkg::*;
#(
  parameter int FRAME_BITS  = 32,
  parameter int BUSY_CYCLES = 50000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclk,
  input  logic     latchN,
  input  logic     mosi,
  input  logic     copyIssued,
  output ctrlStb_t stb,
  output logic     mosiS,
  output logic     latchLow,
  output logic     busy
);

  localparam int CW    = $clog2(FRAME_BITS + 2);
  localparam int BW    = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(FRAME_BITS + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);
  localparam logic [BW-1:0] BUSY_END = BW'(BUSY_CYCLES - 1);

  logic [1:0] sclkSy, latchSy, mosiSy;
  logic sclkPrev, latchPrev;
  logic sclkS, latchS;
  logic sclkRise, sclkFall, latchFall, latchRise;
  logic active;
  logic [CW-1:0] bitCnt;
  logic [BW-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkSy    <= 2'b00;
      latchSy   <= 2'b11;
      mosiSy    <= 2'b00;
      sclkPrev  <= 1'b0;
      latchPrev <= 1'b1;
    end else begin
      sclkSy    <= {sclkSy[0], sclk};
      latchSy   <= {latchSy[0], latchN};
      mosiSy    <= {mosiSy[0], mosi};
      sclkPrev  <= sclkSy[1];
      latchPrev <= latchSy[1];
    end
  end

  assign sclkS     = sclkSy[1];
  assign latchS    = latchSy[1];
  assign mosiS     = mosiSy[1];
  assign sclkRise  = sclkS & ~sclkPrev;
  assign sclkFall  = ~sclkS & sclkPrev;
  assign latchFall = ~latchS & latchPrev;
  assign latchRise = latchS & ~latchPrev;
  assign latchLow  = ~latchS;

  assign stb.start    = latchFall;
  assign stb.shiftIn  = active & sclkRise & ~latchS;
  assign stb.shiftOut = sclkFall & ~latchS;
  assign stb.commit   = active & latchRise & (bitCnt == CNT_FULL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      bitCnt <= '0;
    end else if (latchFall) begin
      active <= ~busy;
      bitCnt <= '0;
    end else if (latchRise) begin
      active <= 1'b0;
    end else if (stb.shiftIn && bitCnt != CNT_MAX) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      busyCnt <= '0;
    end else if (copyIssued) begin
      busy    <= 1'b1;
      busyCnt <= '0;
    end else if (busy) begin
      if (busyCnt == BUSY_END) busy <= 1'b0;
      else busyCnt <= busyCnt + 1'b1;
    end
  end

  // R8: a frame opened during the busy window never reaches commit
  a_r8_no_commit_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !stb.commit);

  // R2: nothing is shifted in unless latch enable was already low
  a_r2_shift_when_low: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftIn |-> $past(!latchS));

endmodule

// File: rtl/cfgspi_regs.sv
module cfgspi_regs
  import cfgspi_pkg::*;
#(
  parameter int NREG  = 9,
  parameter int NSAVE = 8,
  parameter int DW    = 28,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             porN,
  input  ctrlStb_t         stb,
  input  logic             mosiS,
  output logic             copyIssued,
  output logic             miso,
  output logic [NREG*DW-1:0] regFlat
);

  localparam int FW = DW + AW;

  logic [FW-1:0] shiftReg;
  logic [FW-1:0] outShift;
  logic [AW-1:0] code, readSel;
  logic [DW-1:0] dat, selVal;
  logic [DW-1:0] regs   [NREG];
  logic [DW-1:0] shadow [NSAVE];
  logic [NSAVE*DW-1:0] shadowFlat;
  logic locked;
  logic isWrite, isRead, isCopyKey, isLockKey, doCopy;

  assign code = shiftReg[AW-1:0];
  assign dat  = shiftReg[FW-1:AW];

  always_ff @(posedge clk) begin
    if (!rstN || !porN) shiftReg <= '0;
    else if (stb.shiftIn) shiftReg <= {mosiS, shiftReg[FW-1:1]};
  end

  assign isWrite   = stb.commit && (code < AW'(NREG));
  assign isRead    = stb.commit && (code == CODE_READ);
  assign isCopyKey = stb.commit && (code == CODE_COPY) && (dat == DW'(KEY_COPY));
  assign isLockKey = stb.commit && (code == CODE_COPY) && (dat == DW'(KEY_LOCK));
  assign doCopy    = (isCopyKey || isLockKey) && !locked;
  assign copyIssued = doCopy;

  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_reg
      if (gi < NSAVE) begin : g_saved
        always_ff @(posedge clk) begin
          if (!porN)                            regs[gi] <= DW'(shadowDefault(gi));
          else if (!rstN)                       regs[gi] <= shadow[gi];
          else if (isWrite && code == AW'(gi))  regs[gi] <= dat;
        end
        always_ff @(posedge clk) begin
          if (!porN)       shadow[gi] <= DW'(shadowDefault(gi));
          else if (doCopy) shadow[gi] <= regs[gi];
        end
        assign shadowFlat[gi*DW +: DW] = shadow[gi];
      end else begin : g_volatile
        always_ff @(posedge clk) begin
          if (!porN || !rstN)                   regs[gi] <= '0;
          else if (isWrite && code == AW'(gi))  regs[gi] <= dat;
        end
      end
      assign regFlat[gi*DW +: DW] = regs[gi];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!porN)                   locked <= 1'b0;
    else if (doCopy && isLockKey) locked <= 1'b1;
  end

  always_comb begin
    selVal = '0;
    for (int i = 0; i < NREG; i++)
      if (readSel == AW'(i)) selVal = regs[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN || !porN) begin
      readSel  <= '0;
      outShift <= '0;
    end else begin
      if (isRead) readSel <= dat[AW-1:0];
      if (stb.start)         outShift <= {selVal, readSel};
      else if (stb.shiftOut) outShift <= {1'b0, outShift[FW-1:1]};
    end
  end

  assign miso = outShift[0];

  // R7: once set, the lock holds until power-on reset
  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!porN)
    locked |=> locked);

  // R7: a locked shadow never changes
  a_r7_shadow_frozen: assert property (@(posedge clk) disable iff (!porN)
    locked |=> $stable(shadowFlat));

  // R3: registers change only on a committed frame
  a_r3_regs_on_commit: assert property (@(posedge clk) disable iff (!rstN || !porN)
    !stb.commit |=> $stable(regFlat));

  // R4: the read-back word moves only on frame start or a falling serial edge
  a_r4_out_idle: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (!stb.start && !stb.shiftOut) |=> $stable(outShift));

endmodule

// File: rtl/cfg_spi_slave.sv
module cfg_spi_slave
  import cfgspi_pkg::*;
#(
  parameter int NREG        = 9,
  parameter int NSAVE       = 8,
  parameter int DW          = 28,
  parameter int AW          = 4,
  parameter int BUSY_CYCLES = 50000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               porN,
  input  logic               sclk,
  input  logic               latchN,
  input  logic               mosi,
  output logic               miso,
  output logic               misoEn,
  output logic               busy,
  output logic [NREG*DW-1:0] regFlat
);

  localparam int FRAME_BITS = DW + AW;

  ctrlStb_t stb;
  logic mosiS, copyIssued, rstAll;

  assign rstAll = rstN & porN;

  cfgspi_ctrl #(.FRAME_BITS(FRAME_BITS), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstAll), .sclk(sclk), .latchN(latchN), .mosi(mosi),
    .copyIssued(copyIssued), .stb(stb), .mosiS(mosiS), .latchLow(misoEn), .busy(busy)
  );

  cfgspi_regs #(.NREG(NREG), .NSAVE(NSAVE), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rstN(rstN), .porN(porN), .stb(stb), .mosiS(mosiS),
    .copyIssued(copyIssued), .miso(miso), .regFlat(regFlat)
  );

endmodule

// File: tb/sim_cfg_spi_slave.sv
module sim_cfg_spi_slave;

  localparam int BUSY = 300;

  logic clk = 1'b0, rstN = 1'b0, porN = 1'b0;
  logic sclk = 1'b0, latchN = 1'b1, mosi = 1'b0;
  logic miso, misoEn, busy;
  logic [251:0] regFlat;

  int errors = 0, checks = 0;
  logic [27:0] expReg [9];
  logic [27:0] expShadow [8];
  bit done = 0;

  always #2 clk = ~clk;

  cfg_spi_slave #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rstN(rstN), .porN(porN), .sclk(sclk), .latchN(latchN), .mosi(mosi),
    .miso(miso), .misoEn(misoEn), .busy(busy), .regFlat(regFlat)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [31:0] f, input int nbits, output logic [31:0] got, output bit enSeen);
    got = '0;
    latchN = 1'b0;
    tick(6);
    enSeen = misoEn;
    for (int i = 0; i < nbits; i++) begin
      mosi = f[i % 32];
      tick(4);
      if (i < 32) got[i] = miso;
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
    end
    tick(4);
    latchN = 1'b1;
    tick(8);
  endtask

  task automatic frame(input logic [31:0] f);
    logic [31:0] g; bit e;
    sendFrame(f, 32, g, e);
  endtask

  task automatic checkRegs(input string req);
    for (int i = 0; i < 9; i++)
      chk(regFlat[i*28 +: 28] == expReg[i], req, {4'h0, regFlat[i*28 +: 28]}, {4'h0, expReg[i]});
  endtask

  function automatic logic [27:0] pat(input int a, input int k);
    return 28'((a + 3) * 32'h0123457 + k * 32'h0ABCDEF);
  endfunction

  task automatic loadDefaults();
    for (int i = 0; i < 8; i++)
      expShadow[i] = (i <= 4) ? 28'h8140000 : (i == 5) ? 28'h0000096 : (i == 7) ? 28'h9400000 : 28'h0;
  endtask

  task automatic reloadExp();
    for (int i = 0; i < 8; i++) expReg[i] = expShadow[i];
    expReg[8] = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] got; bit en;
    tick(5);
    rstN = 1'b1; porN = 1'b1;
    tick(3);
    loadDefaults();
    reloadExp();
    checkRegs("R9 power-on defaults");
    chk(misoEn == 1'b0, "R10 idle enable", {31'h0, misoEn}, 32'h0);
    chk(busy == 1'b0, "R8 idle busy", {31'h0, busy}, 32'h0);

    // R3 / R1: sweep writes over every register with two patterns
    for (int k = 0; k < 2; k++) begin
      for (int a = 0; a < 9; a++) begin
        frame({pat(a, k), 4'(a)});
        expReg[a] = pat(a, k);
      end
      checkRegs("R3 write sweep");
    end

    // R2: serial clock pulses while latch high do nothing
    mosi = 1'b1;
    for (int i = 0; i < 10; i++) begin sclk = 1'b1; tick(4); sclk = 1'b0; tick(4); end
    checkRegs("R2 idle clocks");
    frame({28'h1357BDF, 4'd2});
    expReg[2] = 28'h1357BDF;
    checkRegs("R2 frame after idle clocks");

    // R5: short and long frames are discarded
    begin
      logic [31:0] g; bit e;
      sendFrame({28'hFFFFFFF, 4'd3}, 31, g, e);
      checkRegs("R5 31-bit frame");
      sendFrame({28'hEEEEEEE, 4'd4}, 33, g, e);
      checkRegs("R5 33-bit frame");
    end

    // R11: unused codes and wrong keys
    for (int c = 9; c <= 13; c++) frame({pat(c, 5), 4'(c)});
    frame({28'h0000002, 4'hF});
    chk(busy == 1'b0, "R11 wrong key busy", {31'h0, busy}, 32'h0);
    checkRegs("R11 unused codes");

    // R4 / R10: read-back of every target, plus out-of-range targets
    for (int t = 0; t < 11; t++) begin
      logic [27:0] v;
      frame({24'h0, 4'(t), 4'hE});
      chk(misoEn == 1'b0, "R10 enable low between frames", {31'h0, misoEn}, 32'h0);
      sendFrame({24'h0, 4'(t), 4'hE}, 32, got, en);
      v = (t < 9) ? expReg[t] : 28'h0;
      chk(got == {v, 4'(t)}, "R4 read-back", got, {v, 4'(t)});
      chk(en == 1'b1, "R10 enable during frame", {31'h0, en}, 32'h1);
    end

    // R6 / R8: unlocked copy, busy window, frame ignored while busy
    frame({28'h0000001, 4'hF});
    for (int i = 0; i < 8; i++) expShadow[i] = expReg[i];
    chk(busy == 1'b1, "R8 busy after copy", {31'h0, busy}, 32'h1);
    frame({28'h2222222, 4'd0});
    checkRegs("R8 frame during busy ignored");
    tick(BUSY + 20);
    chk(busy == 1'b0, "R8 busy ends", {31'h0, busy}, 32'h0);
    frame({28'h3333333, 4'd0}); expReg[0] = 28'h3333333;
    frame({28'h4444444, 4'd8}); expReg[8] = 28'h4444444;
    rstN = 1'b0; tick(3); rstN = 1'b1; tick(2);
    reloadExp();
    checkRegs("R9 warm reload after copy");

    // R6: repeated unlocked copy
    frame({28'h5555555, 4'd6}); expReg[6] = 28'h5555555;
    frame({28'h0000001, 4'hF});
    for (int i = 0; i < 8; i++) expShadow[i] = expReg[i];
    tick(BUSY + 20);
    frame({28'h0, 4'd6}); expReg[6] = 28'h0;
    rstN = 1'b0; tick(3); rstN = 1'b1; tick(2);
    reloadExp();
    checkRegs("R6 second copy");

    // R7: lock, then later copies change nothing
    frame({28'h7777777, 4'd1}); expReg[1] = 28'h7777777;
    frame({28'h0000A03, 4'hF});
    for (int i = 0; i < 8; i++) expShadow[i] = expReg[i];
    chk(busy == 1'b1, "R7 lock copy busy", {31'h0, busy}, 32'h1);
    tick(BUSY + 20);
    frame({28'h1111111, 4'd1}); expReg[1] = 28'h1111111;
    checkRegs("R7 writes after lock");
    frame({28'h0000001, 4'hF});
    chk(busy == 1'b0, "R7 locked copy no busy", {31'h0, busy}, 32'h0);
    frame({28'h0000A03, 4'hF});
    chk(busy == 1'b0, "R7 locked relock no busy", {31'h0, busy}, 32'h0);
    rstN = 1'b0; tick(3); rstN = 1'b1; tick(2);
    reloadExp();
    checkRegs("R7 shadow frozen");

    // R9: power-on restores defaults and unlocks
    porN = 1'b0; tick(3); porN = 1'b1; tick(2);
    loadDefaults(); reloadExp();
    checkRegs("R9 power-on after lock");
    frame({28'h0000001, 4'hF});
    chk(busy == 1'b1, "R9 unlocked after power-on", {31'h0, busy}, 32'h1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule